// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the lowest address bits used for a four-beat burst in a synchronous static memory. A load command takes a starting address. Each later advance command moves to the next beat. The step order is either a plain modulo-four count or an exclusive-OR walk, and a static, active-low select input picks between them. After four beats the sequence returns to the starting address, so further advances repeat it.

The upper address bits are not handled here and the memory array is out of scope. The surrounding memory controller drives the commands once per clock. It uses the clock enable to freeze the burst state, for example during a stalled bus cycle. The output reaches array decode through combinational logic from two registers: the captured start and a beat counter.

Top module: `burst_addr_seq`

## Requirements
- R1: After a synchronous active-low reset (`rst_n` low at a rising edge), `burst_addr` is 00.
- R2: With `clk_en` high and `load` high at a rising edge, `burst_addr` equals the `start_addr` sampled at that edge from then on, until the next advance, and the beat count restarts at zero.
- R3: When `order_lin_n` is 0 (linear order), the address after k advances since the load is (start + k) modulo 4. For example, a start of 01 gives 01, 10, 11, 00.
- R4: When `order_lin_n` is 1 (interleaved order), the address after k advances since the load is start XOR (k modulo 4). For example, a start of 10 gives 10, 11, 00, 01.
- R5: The fourth advance after a load brings `burst_addr` back to the start value, and further advances repeat the same four-beat sequence.
- R6: While `clk_en` is low, a rising edge changes no state, whatever `load`, `advance` and `start_addr` are.
- R7: When `load` and `advance` are both high with `clk_en` high, the load wins. The output becomes the new start and no step is taken.
- R8: With `clk_en` high and both `load` and `advance` low, a rising edge leaves `burst_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock enable; low freezes all state |
| load | input | 1 | Capture a new burst start address |
| advance | input | 1 | Step to the next beat of the burst |
| start_addr | input | 2 | Starting low address bits of the burst |
| order_lin_n | input | 1 | Burst order select: 0 linear, 1 interleaved |
| burst_addr | output | 2 | Current low address bits for array decode |

## Verification
The bench goes after four corner cases.

- **Wrap point.** A counter that saturated, or that cleared to 00 instead of to the start, would show a wrong address on the fifth beat. The bench runs nine advances from every start in both orders to catch this.
- **Order confusion.** Adding where an exclusive-OR belongs only differs from some starts. A start of 01 or 11 exposes it, and the sweep covers those starts.
- **Load against advance.** The bench issues both in the same cycle. A design that stepped first would present start+1.
- **Stalled cycles.** The bench pulses `load` and `advance` while `clk_en` is low. A design that ignored the enable would move the address.

// File: rtl/burst_seq_pkg.sv
// Package: shared sizing and order encoding for the burst address sequencer.
// Assumes a power-of-two burst length addressed by the low address bits.
package burst_seq_pkg;

    // Order select value as seen on the active-low pin.
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // Address for a given beat: sum or XOR of start and beat index.
    function automatic logic [1:0] beat_addr2(input logic [1:0] base,
                                              input logic [1:0] beat,
                                              input burst_order_e ord);
        beat_addr2 = (ord == ORD_LINEAR) ? 2'(base + beat) : (base ^ beat);
    endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
// Module: holds the captured burst start and the beat index.
// Load resets the beat index and wins over advance; clk_en low freezes both.
// Assumes the beat index wraps naturally at 2**ADDR_W beats.
module burst_beat_ctr #(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] beat_q
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] base_d;
    logic [ADDR_W-1:0] beat_d;

    // Next-state choice: enable gate, then load priority, then step.
    always_comb begin
        base_d = base_q;
        beat_d = beat_q;
        if (clk_en) begin
            if (load) begin
                base_d = start_addr;
                beat_d = '0;
            end else if (advance) begin
                beat_d = beat_q + ONE;
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else begin
            base_q <= base_d;
            beat_q <= beat_d;
        end
    end

    AST_FROZEN_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(base_q) && $stable(beat_q))); // R6
    AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && load) |=> (beat_q == '0 && base_q == $past(start_addr))); // R2
    AST_LOAD_BEATS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && load && advance) |=> (beat_q == '0)); // R7
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !load && advance) |=> (beat_q == $past(beat_q) + ONE && $stable(base_q))); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !load && !advance) |=> ($stable(beat_q) && $stable(base_q))); // R8
endmodule

// File: rtl/burst_order_map.sv
// Module: combinational map from (start, beat index) to the beat address.
// Linear order adds the index modulo 2**ADDR_W; interleaved order XORs it.
// Assumes order_sel is static during a burst; a change takes effect at once.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] beat,
    input  burst_order_e      order_sel,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] lin_addr;
    logic [ADDR_W-1:0] ilv_addr;

    // Linear path: modular sum of start and beat index.
    always_comb lin_addr = base + beat;

    // Interleaved path: bitwise exclusive-OR per address bit.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_ilv
        assign ilv_addr[b] = base[b] ^ beat[b];
    end

    // Output select by the burst order input.
    always_comb addr = (order_sel == ORD_LINEAR) ? lin_addr : ilv_addr;

    AST_FIRST_BEAT_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (beat == '0) |-> (addr == base)); // R2
    AST_ILV_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        (order_sel == ORD_INTERLEAVE) |-> ((addr ^ beat) == base)); // R4
    AST_LIN_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (order_sel == ORD_LINEAR) |-> (ADDR_W'(addr - base) == beat)); // R3
endmodule

// File: rtl/burst_addr_seq.sv
// Module: top of the burst address sequencer.
// Joins the start/beat registers to the order map and presents the low
// address bits for the current beat. Assumes a four-beat burst (ADDR_W=2).
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              order_lin_n,
    output logic [ADDR_W-1:0] burst_addr
);
    localparam int BEATS = 1 << ADDR_W;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] beat_q;
    burst_order_e      order_sel;

    // Decode the active-low order pin into the order type.
    always_comb order_sel = order_lin_n ? ORD_INTERLEAVE : ORD_LINEAR;

    burst_beat_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .load       (load),
        .advance    (advance),
        .start_addr (start_addr),
        .base_q     (base_q),
        .beat_q     (beat_q)
    );

    burst_order_map #(.ADDR_W(ADDR_W)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .base      (base_q),
        .beat      (beat_q),
        .order_sel (order_sel),
        .addr      (burst_addr)
    );

    initial begin
        AST_BEATS_MIN: assert (BEATS >= 2); // R5
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (burst_addr == '0)); // R1
    AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && $stable(order_lin_n)) |=> $stable(burst_addr)); // R6
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       load = 1'b0;
    logic       advance = 1'b0;
    logic [1:0] start_addr = 2'b00;
    logic       order_lin_n = 1'b0;
    logic [1:0] burst_addr;

    int checks = 0;
    int failures = 0;

    burst_addr_seq dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .load(load),
        .advance(advance), .start_addr(start_addr),
        .order_lin_n(order_lin_n), .burst_addr(burst_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Drive at negedge, let one rising edge pass, return at the next negedge.
    task automatic cycle(input logic en, input logic ld, input logic adv, input logic [1:0] st);
        clk_en = en; load = ld; advance = adv; start_addr = st;
        @(posedge clk);
        @(negedge clk);
        clk_en = 1'b0; load = 1'b0; advance = 1'b0;
    endtask

    task automatic check(input string req, input logic [1:0] exp);
        checks++;
        if (burst_addr !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, burst_addr, exp);
        end
    endtask

    function automatic logic [1:0] model(input logic [1:0] s, input int k, input logic ilv);
        logic [1:0] kk;
        kk = 2'(k % 4);
        return ilv ? (s ^ kk) : 2'((s + kk) % 4);
    endfunction

    initial begin
        @(negedge clk);
        cycle(1'b1, 1'b1, 1'b1, 2'b11);  // reset held: ignored
        rst_n = 1'b1;
        check("R1", 2'b00);

        // R3/R4/R5 sweep: all starts, both orders, nine advances
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 4; s++) begin
                order_lin_n = o[0];
                cycle(1'b1, 1'b1, 1'b0, 2'(s));
                check("R2", 2'(s));
                for (int k = 1; k <= 9; k++) begin
                    cycle(1'b1, 1'b0, 1'b1, 2'(s));
                    check(o == 0 ? "R3" : "R4", model(2'(s), k, o[0]));
                    if (k % 4 == 0) check("R5", 2'(s));
                end
            end
        end

        // R6: enable low blocks load and advance
        order_lin_n = 1'b0;
        cycle(1'b1, 1'b1, 1'b0, 2'b01);
        cycle(1'b1, 1'b0, 1'b1, 2'b01);
        check("R3", 2'b10);
        cycle(1'b0, 1'b1, 1'b0, 2'b11);
        check("R6", 2'b10);
        cycle(1'b0, 1'b0, 1'b1, 2'b00);
        check("R6", 2'b10);
        cycle(1'b1, 1'b0, 1'b1, 2'b00);
        check("R6", 2'b11);

        // R8: idle cycles with enable high hold
        cycle(1'b1, 1'b0, 1'b0, 2'b00);
        check("R8", 2'b11);
        cycle(1'b1, 1'b0, 1'b0, 2'b01);
        check("R8", 2'b11);

        // R7: load and advance together, then a step from the new start
        for (int o = 0; o < 2; o++) begin
            order_lin_n = o[0];
            cycle(1'b1, 1'b1, 1'b1, 2'b01);
            check("R7", 2'b01);
            cycle(1'b1, 1'b0, 1'b1, 2'b00);
            check("R7", model(2'b01, 1, o[0]));
            cycle(1'b1, 1'b1, 1'b1, 2'b10);
            check("R7", 2'b10);
        end

        // R1: reset mid-burst returns to 00
        rst_n = 1'b0;
        cycle(1'b1, 1'b0, 1'b1, 2'b00);
        rst_n = 1'b1;
        check("R1", 2'b00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule